// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host and an external 16-bit asynchronous static RAM with a 17-bit word address. The host issues one access at a time. Each request carries an address, a direction, write data and a two-bit byte mask. The controller turns the request into a sequence of active-low memory strobes, and each phase of that sequence lasts a whole number of clock cycles. Read data returns through a registered port with a one-cycle valid pulse.

Writes are write-enable controlled. Chip enable and the selected byte lanes fall first, together with the start of data drive. Write enable then pulses low. The write ends when write enable rises, and the data bus is released on that same edge. Output enable stays high for the whole write, so the memory's own bus turn-around never lengthens a write. The controller tracks bus ownership itself. It waits for a settling window after a read before it drives write data, and it leaves one quiet cycle after a write before it enables the memory outputs. A request whose mask is all zero completes without touching any strobe.

All phase lengths are parameters given in clock cycles. The defaults suit a 10 ns clock: a 7-cycle read window, a 5-cycle write-enable pulse, 3 cycles of data set-up and 3 cycles of turn-around.

Top module: `sram_ctl`

## Requirements
- R1: During and after reset, chip enable, write enable, output enable and both lane enables are high, the data bus is not driven, the response valid is low and the request ready is high.
- R2: A read holds chip enable and output enable low and write enable high for exactly RD_WAIT cycles (default 7), presents the request address throughout, and drives the lower lane enable low when mask bit 0 is set and the upper lane enable low when mask bit 1 is set.
- R3: Read data is sampled from the memory input bus in the last cycle of the read window and returned with a one-cycle valid pulse in the cycle right after output enable rises. A byte whose mask bit is clear is returned as zero (bits 7:0 belong to mask bit 0, bits 15:8 to mask bit 1).
- R4: A write drives write enable low for exactly WE_LOW cycles (default 5), with chip enable and the selected lane enables low over those cycles and the set-up cycle before them, and output enable high throughout.
- R5: The write data bus is driven with the request data, unchanged, from the set-up cycle before write enable falls until write enable rises, and is released on the same edge. This is 6 driven cycles with the defaults.
- R6: A write changes only the bytes selected by the mask. The byte of an unselected lane keeps its previous content.
- R7: A request with mask 2'b00 strobes nothing. Ready is low for exactly one cycle. A read of this kind returns valid with data zero in that cycle.
- R8: After output enable rises, the controller does not start driving the data bus until output enable has been high for at least TURN cycles (default 3).
- R9: Output enable never falls in the cycle right after a cycle in which the controller drove the data bus.
- R10: Ready is low from the cycle after a request is accepted until the access completes: 8 cycles for a read and 7 for a write that needs no turn-around wait. Requests presented while ready is low are ignored.
- R11: The memory address does not change while chip enable is low, and chip enable is never low with both lane enables high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; a request is taken on a cycle where valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte select; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Registered read data |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_lo_n | output | 1 | Lower byte lane enable, active low |
| mem_lane_hi_n | output | 1 | Upper byte lane enable, active low |
| mem_dq_out | output | 16 | Write data toward the memory |
| mem_dq_oe | output | 1 | Data bus drive enable, active high |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
A phase counter that is off by one shows up at once as a strobe window of the wrong length. The bench counts that window on the strobe pins in the same access, and it also sees the response pulse move by a cycle. If the sequencer holds the wrong mask or address, the wrong lane enables or a wrong address appear while the strobes are active. The effect on memory content then shows up in the read-back that follows. A broken bus-ownership tracker lets the data drive enable rise too soon after a read, or lets output enable fall right after a write. The bench catches both at the first write that follows a read and at the first read that follows a write.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_READ,
        ST_PRE,
        ST_PULSE,
        ST_CLOSE
    } phase_t;

    typedef struct packed {
        logic             write;
        logic [LANES-1:0] mask;
    } op_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic lo_n;
        logic hi_n;
        logic drive;
    } pins_t;

    localparam pins_t PINS_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                    lo_n: 1'b1, hi_n: 1'b1, drive: 1'b0};

    // Strobe pattern for the phase the sequencer is entering.
    function automatic pins_t pins_for(phase_t ph, logic [LANES-1:0] mask);
        pins_t p;
        p = PINS_IDLE;
        if (ph == ST_READ || ph == ST_PRE || ph == ST_PULSE) begin
            p.ce_n = 1'b0;
            p.lo_n = ~mask[0];
            p.hi_n = ~mask[1];
        end
        case (ph)
            ST_READ:  p.oe_n  = 1'b0;
            ST_PRE:   p.drive = 1'b1;
            ST_PULSE: begin
                p.drive = 1'b1;
                p.we_n  = 1'b0;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctl_guard.sv
// Bus ownership tracker: tells the sequencer when the shared data bus is
// safe for the memory to drive (read) or for the controller to drive (write).
module sram_ctl_guard #(
    parameter int TURN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_n,
    input  logic drive,
    output logic rd_clear,
    output logic wr_clear
);
    localparam int TW = $clog2(TURN + 2);

    logic [TW-1:0] oe_hi_q;
    logic          quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_hi_q <= TW'(TURN);
            quiet_q <= 1'b1;
        end else begin
            if (!oe_n)
                oe_hi_q <= '0;
            else if (oe_hi_q < TW'(TURN))
                oe_hi_q <= oe_hi_q + 1'b1;
            quiet_q <= ~drive;
        end
    end

    assign wr_clear = oe_n && (oe_hi_q >= TW'(TURN));
    assign rd_clear = quiet_q && !drive;
endmodule

// File: rtl/sram_ctl_seq.sv
// Access sequencer: accepts one request, walks the strobe phases and
// registers the strobe pattern for each phase.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int AW      = 17,
    parameter int RD_WAIT = 7,
    parameter int WE_LOW  = 5,
    parameter int SETUP   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  logic              rd_clear,
    input  logic              wr_clear,
    output logic              req_ready,
    output pins_t             pins_q,
    output logic [AW-1:0]     addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  mask_q,
    output logic              cap_read,
    output logic              null_read
);
    // Cycles of data drive before write enable falls.
    localparam int PRE  = (SETUP > WE_LOW) ? (SETUP - WE_LOW) : 1;
    localparam int MAXA = (RD_WAIT > WE_LOW) ? RD_WAIT : WE_LOW;
    localparam int MAXC = (MAXA > PRE) ? MAXA : PRE;
    localparam int CW   = $clog2(MAXC + 1);

    phase_t        ph_q, ph_d;
    logic [CW-1:0] cnt_q, cnt_d;
    op_t           op_q, op_d, go_op;
    logic          accept, go_clear;

    assign accept    = req_valid && (ph_q == ST_IDLE);
    assign req_ready = (ph_q == ST_IDLE);
    assign go_op     = (ph_q == ST_IDLE) ? '{write: req_write, mask: req_mask} : op_q;
    assign go_clear  = go_op.write ? wr_clear : rd_clear;

    always_comb begin
        ph_d      = ph_q;
        op_d      = op_q;
        cnt_d     = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
        cap_read  = 1'b0;
        null_read = 1'b0;
        case (ph_q)
            ST_IDLE, ST_HOLD: begin
                if (ph_q == ST_HOLD || req_valid) begin
                    op_d = go_op;
                    if (go_op.mask == '0) begin
                        ph_d      = ST_CLOSE;
                        null_read = ~go_op.write;
                    end else if (go_clear) begin
                        ph_d  = go_op.write ? ST_PRE : ST_READ;
                        cnt_d = go_op.write ? CW'(PRE - 1) : CW'(RD_WAIT - 1);
                    end else begin
                        ph_d = ST_HOLD;
                    end
                end
            end
            ST_READ: begin
                if (cnt_q == '0) begin
                    ph_d     = ST_CLOSE;
                    cap_read = 1'b1;
                end
            end
            ST_PRE: begin
                if (cnt_q == '0) begin
                    ph_d  = ST_PULSE;
                    cnt_d = CW'(WE_LOW - 1);
                end
            end
            ST_PULSE: begin
                if (cnt_q == '0)
                    ph_d = ST_CLOSE;
            end
            ST_CLOSE: ph_d = ST_IDLE;
            default:  ph_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= ST_IDLE;
            cnt_q   <= '0;
            op_q    <= '0;
            pins_q  <= PINS_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            op_q   <= op_d;
            pins_q <= pins_for(ph_d, op_d.mask);
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    assign mask_q = op_q.mask;
endmodule

// File: rtl/sram_ctl_capture.sv
// Read data register: keeps the selected lanes, zeroes the rest.
module sram_ctl_capture
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_read,
    input  logic              null_read,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [DATA_W-1:0] kept;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign kept[l*LANE_W +: LANE_W] = mask[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cap_read | null_read;
            if (cap_read)
                rsp_rdata <= kept;
            else if (null_read)
                rsp_rdata <= '0;
        end
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW      = 17,
    parameter int RD_WAIT = 7,
    parameter int WE_LOW  = 5,
    parameter int SETUP   = 3,
    parameter int TURN    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lane_lo_n,
    output logic              mem_lane_hi_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    pins_t            pins;
    logic             rd_clear, wr_clear, cap_read, null_read;
    logic [LANES-1:0] mask_q;

    sram_ctl_seq #(
        .AW(AW), .RD_WAIT(RD_WAIT), .WE_LOW(WE_LOW), .SETUP(SETUP)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_clear(rd_clear), .wr_clear(wr_clear),
        .req_ready(req_ready), .pins_q(pins), .addr_q(mem_addr),
        .wdata_q(mem_dq_out), .mask_q(mask_q),
        .cap_read(cap_read), .null_read(null_read)
    );

    sram_ctl_guard #(.TURN(TURN)) u_guard (
        .clk(clk), .rst(rst),
        .oe_n(pins.oe_n), .drive(pins.drive),
        .rd_clear(rd_clear), .wr_clear(wr_clear)
    );

    sram_ctl_capture u_cap (
        .clk(clk), .rst(rst),
        .cap_read(cap_read), .null_read(null_read),
        .mask(mask_q), .dq_in(mem_dq_in),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    assign mem_ce_n      = pins.ce_n;
    assign mem_we_n      = pins.we_n;
    assign mem_oe_n      = pins.oe_n;
    assign mem_lane_lo_n = pins.lo_n;
    assign mem_lane_hi_n = pins.hi_n;
    assign mem_dq_oe     = pins.drive;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int AW     = 17,
    parameter int DW     = 16,
    parameter int WE_LOW = 5,
    parameter int TURN   = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_lane_lo_n,
    input logic          mem_lane_hi_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);
    int   we_run, oe_hi_run;
    logic prev_we_n, prev_oe_n, prev_drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run     <= 0;
            oe_hi_run  <= TURN;
            prev_we_n  <= 1'b1;
            prev_oe_n  <= 1'b1;
            prev_drive <= 1'b0;
        end else begin
            we_run     <= mem_we_n ? 0 : we_run + 1;
            oe_hi_run  <= !mem_oe_n ? 0 : ((oe_hi_run < TURN) ? oe_hi_run + 1 : oe_hi_run);
            prev_we_n  <= mem_we_n;
            prev_oe_n  <= mem_oe_n;
            prev_drive <= mem_dq_oe;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid)); // R1
    AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_dq_oe)); // R2
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R3
    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n)); // R4
    AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        (mem_we_n && !prev_we_n) |-> (we_run == WE_LOW)); // R4
    AST_DRIVE_UNDER_WE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe); // R5
    AST_DATA_STEADY: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && prev_drive) |-> $stable(mem_dq_out)); // R5
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && !prev_drive) |-> (oe_hi_run >= TURN)); // R8
    AST_RELEASE_BEFORE_OE: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n && prev_oe_n) |-> !prev_drive); // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> !req_ready); // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R11
    AST_NO_STANDBY_SELECT: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> !(mem_lane_lo_n && mem_lane_hi_n)); // R11
endmodule

bind sram_ctl sram_ctl_chk #(
    .AW(AW), .DW(sram_ctl_pkg::DATA_W), .WE_LOW(WE_LOW), .TURN(TURN)
) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lane_lo_n(mem_lane_lo_n),
    .mem_lane_hi_n(mem_lane_hi_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
    localparam int TURN = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lane_lo_n, mem_lane_hi_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    sram_ctl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lane_lo_n(mem_lane_lo_n),
        .mem_lane_hi_n(mem_lane_hi_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model (indexed by the low address byte) and the bench's own shadow.
    logic [15:0] model  [0:255];
    logic [15:0] shadow [0:255];
    logic        pend = 1'b0;
    logic [7:0]  p_idx;
    logic [15:0] p_dat;
    logic [1:0]  p_lane;

    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ?
        {(!mem_lane_hi_n ? model[mem_addr[7:0]][15:8] : 8'hEE),
         (!mem_lane_lo_n ? model[mem_addr[7:0]][7:0]  : 8'hEE)} : 16'hBAD0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Protocol monitor at the falling edge.
    int   oe_hi_run = TURN;
    logic prev_drive = 1'b0, prev_oe_n = 1'b1, prev_ce_n = 1'b1;
    logic [16:0] prev_addr = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_ce_n && !mem_we_n) begin
                pend   = 1'b1;
                p_idx  = mem_addr[7:0];
                p_dat  = mem_dq_out;
                p_lane = {!mem_lane_hi_n, !mem_lane_lo_n};
            end else if (pend && mem_we_n) begin
                if (p_lane[0]) model[p_idx][7:0]  = p_dat[7:0];
                if (p_lane[1]) model[p_idx][15:8] = p_dat[15:8];
                pend = 1'b0;
            end
            if (mem_dq_oe && !prev_drive)
                chk(oe_hi_run >= TURN, "R8 oe-high cycles before drive", oe_hi_run, TURN);
            if (!mem_oe_n && prev_oe_n)
                chk(!prev_drive, "R9 bus driven just before oe low", prev_drive, 0);
            if (!mem_ce_n && !prev_ce_n)
                chk(mem_addr == prev_addr, "R11 address moved under ce", mem_addr, prev_addr);
            oe_hi_run  = !mem_oe_n ? 0 : ((oe_hi_run < TURN) ? oe_hi_run + 1 : oe_hi_run);
            prev_drive = mem_dq_oe;
            prev_oe_n  = mem_oe_n;
            prev_ce_n  = mem_ce_n;
            prev_addr  = mem_addr;
        end
    end

    // Per-access statistics.
    int          s_rdy, s_oe, s_we, s_drv, s_ce, s_rsp, s_at, s_abad, s_lbad, s_dbad, s_oew;
    logic [15:0] s_data;

    task automatic run(input bit wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit inject);
        int idx = 0;
        s_rdy = 0; s_oe = 0; s_we = 0; s_drv = 0; s_ce = 0; s_rsp = 0; s_at = 0;
        s_abad = 0; s_lbad = 0; s_dbad = 0; s_oew = 0; s_data = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        do begin
            @(negedge clk);
            idx++;
            if (idx == 1) req_valid = 1'b0;
            if (!req_ready) s_rdy++;
            if (!mem_ce_n) begin
                s_ce++;
                if (mem_addr != a) s_abad++;
                if ({!mem_lane_hi_n, !mem_lane_lo_n} != m) s_lbad++;
            end
            if (!mem_oe_n) s_oe++;
            if (!mem_we_n) begin
                s_we++;
                if (!mem_oe_n) s_oew++;
            end
            if (mem_dq_oe) begin
                s_drv++;
                if (mem_dq_out != d) s_dbad++;
            end
            if (rsp_valid) begin
                s_rsp++; s_data = rsp_rdata; s_at = idx;
            end
            if (inject && idx == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00077;
                req_wdata = 16'h0000; req_mask = 2'b11;
            end
            if (inject && idx == 5) req_valid = 1'b0;
        end while (!req_ready && idx < 200);
    endtask

    function automatic logic [15:0] lanes(input logic [15:0] v, input logic [1:0] m);
        return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
    endfunction

    task automatic t_reset();
        chk(mem_ce_n && mem_we_n && mem_oe_n && mem_lane_lo_n && mem_lane_hi_n,
            "R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_lane_lo_n, mem_lane_hi_n}, 5'h1f);
        chk(!mem_dq_oe && !rsp_valid && req_ready, "R1 bus/rsp/ready",
            {mem_dq_oe, rsp_valid, req_ready}, 3'b001);
    endtask

    task automatic t_read(input logic [16:0] a, input logic [1:0] m, input bit inject);
        logic [15:0] exp = lanes(shadow[a[7:0]], m);
        run(1'b0, a, 16'h0, m, inject);
        chk(s_oe == 7, "R2 oe low cycles", s_oe, 7);
        chk(s_ce == 7 && s_abad == 0 && s_lbad == 0, "R2 ce/addr/lanes", {s_ce[7:0], s_abad[7:0], s_lbad[7:0]}, 24'h070000);
        chk(s_rsp == 1 && s_at == 8, "R3 rsp pulse position", {s_rsp[7:0], s_at[7:0]}, 16'h0108);
        chk(s_data == exp, "R3 read data", s_data, exp);
        chk(s_rdy == 8, "R10 ready low cycles read", s_rdy, 8);
    endtask

    task automatic t_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m, input bit direct);
        run(1'b1, a, d, m, 1'b0);
        if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
        if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
        chk(s_we == 5 && s_oew == 0, "R4 we pulse / oe high", {s_we[7:0], s_oew[7:0]}, 16'h0500);
        chk(s_ce == 6 && s_lbad == 0 && s_abad == 0, "R4 ce/lanes/addr", {s_ce[7:0], s_lbad[7:0], s_abad[7:0]}, 24'h060000);
        chk(s_drv == 6 && s_dbad == 0, "R5 drive window/data", {s_drv[7:0], s_dbad[7:0]}, 16'h0600);
        if (direct) chk(s_rdy == 7, "R10 ready low cycles write", s_rdy, 7);
    endtask

    task automatic t_zero(input bit wr, input logic [16:0] a);
        run(wr, a, 16'hFFFF, 2'b00, 1'b0);
        chk(s_ce == 0 && s_drv == 0, "R7 no strobe on empty mask", {s_ce[7:0], s_drv[7:0]}, 16'h0);
        chk(s_rdy == 1, "R7 ready low one cycle", s_rdy, 1);
        if (!wr) chk(s_rsp == 1 && s_at == 1 && s_data == 16'h0, "R7 empty read response",
                     {s_rsp[7:0], s_at[7:0], s_data}, 32'h01010000);
        else     chk(s_rsp == 0, "R7 no response for empty write", s_rsp, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            model[i]  = {8'(i) ^ 8'h3C, ~8'(i)};
            shadow[i] = {8'(i) ^ 8'h3C, ~8'(i)};
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read(17'h00012, 2'b11, 1'b0);
        t_write(17'h10034, 16'hA1B2, 2'b11, 1'b0);   // follows a read: R8 window
        t_write(17'h00035, 16'hC3D4, 2'b01, 1'b1);
        t_write(17'h00036, 16'hE5F6, 2'b10, 1'b1);
        t_read(17'h10034, 2'b11, 1'b0);               // R6 full word, R9 after write
        t_read(17'h00035, 2'b11, 1'b0);               // R6 upper byte kept
        t_read(17'h00036, 2'b11, 1'b0);               // R6 lower byte kept
        t_read(17'h10034, 2'b01, 1'b0);               // R3 upper byte zeroed
        t_read(17'h10034, 2'b10, 1'b0);               // R3 lower byte zeroed
        t_zero(1'b1, 17'h00040);
        t_read(17'h00040, 2'b11, 1'b0);               // R7 empty write left memory alone
        t_zero(1'b0, 17'h00041);
        t_read(17'h00050, 2'b11, 1'b1);               // R10 request while busy
        t_read(17'h00077, 2'b11, 1'b0);               // R10 ignored write had no effect
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=complete");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule